// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This execution unit handles two 32-bit bit-field instructions in a small processor datapath. One of them pulls a contiguous run of bits out of a source operand and right-aligns it in an otherwise cleared result. The other writes the low bits of a source operand into a chosen bit range of the current destination value and leaves every other destination bit as it was. The unit takes one instruction word per cycle with a valid strobe. It recognises the two opcodes, reads the register index and the immediate fields, builds the field mask, and shifts and merges the data. The result, the destination index and an illegal-encoding flag are all registered.

The two forms encode the field differently. Both put the field's lowest bit position S in bits 4:0. Extract puts the field width W in bits 10:6. Insert puts the position of the field's highest bit, S + W − 1, in bits 10:6, so for insert the width is never held explicitly: the mask is built straight from the two bit positions. Encodings that name an empty or out-of-range field still complete, with a defined result and the illegal flag set.

Top module: `bfx_unit`

## Requirements
- R1: An instruction is accepted when its bits 31:26 equal 6'b011001 and its bits 15:14 are 2'b01 (extract) or 2'b10 (insert). With bits 15:14 at 2'b01, bit 14 selects extract.
- R2: A valid instruction that matches neither form produces no `outValid` pulse.
- R3: `outValid` rises on the clock edge after an accepted instruction is presented and stays high for one cycle per accepted instruction. `outDstIdx` then carries instruction bits 25:21.
- R4: Extract with W = bits 10:6 and S = bits 4:0, where 1 ≤ W and S + W ≤ 32, gives source bits [S+W−1:S] in result bits [W−1:0], with every higher result bit zero, and a low `outIllegal`.
- R5: Extract with a width field of 0 gives a zero result and a high `outIllegal`.
- R6: Extract with S + W > 32 gives a zero result and a high `outIllegal`.
- R7: Insert with top position T = bits 10:6 and T ≥ S writes the low T − S + 1 source bits into result bits [T:S]. All other result bits equal the destination value, and `outIllegal` is low.
- R8: Insert with T < S returns the destination value unchanged and a high `outIllegal`.
- R9: After reset, `outValid`, `outResult`, `outDstIdx` and `outIllegal` are all zero.
- R10: Insert with S = 0 and T = 31 replaces all 32 bits with the source value, and the flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction word is present this cycle |
| instrWord | input | 32 | Instruction word |
| srcVal | input | 32 | Source register value |
| dstVal | input | 32 | Current destination register value |
| outValid | output | 1 | One-cycle result strobe |
| outResult | output | 32 | Registered result |
| outDstIdx | output | 5 | Registered destination register index |
| outIllegal | output | 1 | Registered out-of-range field flag |

## Verification
The bound checker watches several behaviours on every cycle. It checks the one-cycle strobe timing against the opcode pattern and the destination index taken from the word. For extract it checks that every result bit at or above W is zero. For insert it checks that the result bits below S match the earlier destination value, and that a reversed insert field returns the destination unchanged with the flag set. Some behaviours are only visible through the bench's scenarios and its bit-by-bit reference model: the exact field contents, the boundary fields (width 31, position 31, full-word insert, S + W = 33), back-to-back issue, and rejected opcodes.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam logic [5:0] OP_MAJOR = 6'b011001;
  localparam logic [1:0] SUB_EXT  = 2'b01;
  localparam logic [1:0] SUB_INS  = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // load output registers this cycle
    logic insertSel;  // 1 = insert form, 0 = extract form
    logic illegal;    // field out of range
  } bfxStrobe_t;
endpackage

// File: rtl/bfx_ctrl.sv
module bfx_ctrl
  import bfx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       instrWord,
  output bfxStrobe_t        strobe,
  output logic [SH_W-1:0]   shiftAmt,
  output logic [SH_W-1:0]   fieldHi,
  output logic [IDX_W-1:0]  dstIdxNext,
  output logic              outValid
);
  logic isExt, isIns;
  logic extBad, insBad;
  logic [SH_W:0] extEnd;

  always_comb begin
    isExt      = (instrWord[31:26] == OP_MAJOR) && (instrWord[15:14] == SUB_EXT);
    isIns      = (instrWord[31:26] == OP_MAJOR) && (instrWord[15:14] == SUB_INS);
    shiftAmt   = instrWord[SH_W-1:0];
    fieldHi    = instrWord[6 +: SH_W];
    dstIdxNext = instrWord[21 +: IDX_W];
    extEnd     = {1'b0, shiftAmt} + {1'b0, fieldHi};
    extBad     = (fieldHi == '0) || (int'(extEnd) > DATA_W);
    insBad     = fieldHi < shiftAmt;
    strobe.capture   = inValid && (isExt || isIns);
    strobe.insertSel = isIns;
    strobe.illegal   = isIns ? insBad : extBad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobe.capture;
  end
endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath
  import bfx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bfxStrobe_t        strobe,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic [SH_W-1:0]   fieldHi,
  input  logic [IDX_W-1:0]  dstIdxNext,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  output logic [DATA_W-1:0] outResult,
  output logic [IDX_W-1:0]  outDstIdx,
  output logic              outIllegal
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [DATA_W-1:0] extMask, insMask, extVal, insVal, nextVal;

  always_comb begin
    // extract: low W ones; fieldHi holds W
    extMask = (fieldHi == '0) ? '0 : (ALL_ONES >> (DATA_W - int'(fieldHi)));
    extVal  = strobe.illegal ? '0 : ((srcVal >> shiftAmt) & extMask);
    // insert: ones from bit S up to bit T; the width is never formed
    insMask = (ALL_ONES >> (DATA_W - 1 - int'(fieldHi))) & (ALL_ONES << shiftAmt);
    insVal  = strobe.illegal ? dstVal
                             : ((dstVal & ~insMask) | ((srcVal << shiftAmt) & insMask));
    nextVal = strobe.insertSel ? insVal : extVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outResult  <= '0;
      outDstIdx  <= '0;
      outIllegal <= 1'b0;
    end else if (strobe.capture) begin
      outResult  <= nextVal;
      outDstIdx  <= dstIdxNext;
      outIllegal <= strobe.illegal;
    end
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       instrWord,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult,
  output logic [IDX_W-1:0]  outDstIdx,
  output logic              outIllegal
);
  localparam int SH_W = $clog2(DATA_W);

  bfxStrobe_t       strobe;
  logic [SH_W-1:0]  shiftAmt, fieldHi;
  logic [IDX_W-1:0] dstIdxNext;

  bfx_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .strobe(strobe), .shiftAmt(shiftAmt), .fieldHi(fieldHi),
    .dstIdxNext(dstIdxNext), .outValid(outValid)
  );

  bfx_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .shiftAmt(shiftAmt),
    .fieldHi(fieldHi), .dstIdxNext(dstIdxNext), .srcVal(srcVal),
    .dstVal(dstVal), .outResult(outResult), .outDstIdx(outDstIdx),
    .outIllegal(outIllegal)
  );
endmodule

// File: rtl/bfx_checker.sv
module bfx_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] instrWord,
  input logic [31:0] dstVal,
  input logic        outValid,
  input logic [31:0] outResult,
  input logic [4:0]  outDstIdx,
  input logic        outIllegal
);
  logic opHit, opExt, opIns;
  assign opExt = instrWord[31:26] == 6'b011001 && instrWord[15:14] == 2'b01;
  assign opIns = instrWord[31:26] == 6'b011001 && instrWord[15:14] == 2'b10;
  assign opHit = opExt || opIns;

  // R1 / R3: accepted instruction yields strobe next cycle
  p_strobe_after_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    inValid && opHit |=> outValid);
  // R2: nothing accepted, no strobe
  p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && opHit) |=> !outValid);
  // R3: destination index from bits 25:21
  p_dst_idx_r3: assert property (@(posedge clk) disable iff (!rstN)
    inValid && opHit |=> outDstIdx == $past(instrWord[25:21]));
  // R4 / R5: extract clears all bits at and above W
  p_ext_upper_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    inValid && opExt |=> (outResult >> $past(instrWord[10:6])) == 32'd0);
  // R5: zero width flagged, zero result
  p_ext_zero_w_r5: assert property (@(posedge clk) disable iff (!rstN)
    inValid && opExt && instrWord[10:6] == 5'd0 |=> outIllegal && outResult == 32'd0);
  // R7: insert keeps destination bits below S
  p_ins_low_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    inValid && opIns |=>
      ((outResult ^ $past(dstVal)) & ~(32'hFFFF_FFFF << $past(instrWord[4:0]))) == 32'd0);
  // R8: reversed insert field returns destination, flagged
  p_ins_reversed_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid && opIns && instrWord[10:6] < instrWord[4:0] |=>
      outIllegal && outResult == $past(dstVal));
endmodule

bind bfx_unit bfx_checker u_bfx_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
  .dstVal(dstVal), .outValid(outValid), .outResult(outResult),
  .outDstIdx(outDstIdx), .outIllegal(outIllegal)
);

// File: tb/tb_bfx_unit.sv
`timescale 1ns/1ps
module tb_bfx_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] srcVal = '0;
  logic [31:0] dstVal = '0;
  logic        outValid;
  logic [31:0] outResult;
  logic [4:0]  outDstIdx;
  logic        outIllegal;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] res;
    logic [4:0]  idx;
    logic        ill;
    string       tag;
  } expItem_t;
  expItem_t sbQ[$];

  always #5 clk = ~clk;

  bfx_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .srcVal(srcVal), .dstVal(dstVal), .outValid(outValid),
    .outResult(outResult), .outDstIdx(outDstIdx), .outIllegal(outIllegal)
  );

  function automatic logic [31:0] mkWord(bit ins, int rd, int ra, int hi, int s);
    logic [31:0] w;
    w = 32'h6400_0000;
    w[15:14] = ins ? 2'b10 : 2'b01;
    w[25:21] = rd[4:0];
    w[20:16] = ra[4:0];
    w[10:6]  = hi[4:0];
    w[4:0]   = s[4:0];
    return w;
  endfunction

  // bit-by-bit reference, built from the requirements
  task automatic model(input logic [31:0] w, input logic [31:0] src,
                       input logic [31:0] dst, output bit hit,
                       output logic [31:0] res, output logic ill);
    int s, f;
    s = int'(w[4:0]);
    f = int'(w[10:6]);
    hit = 0; res = '0; ill = 0;
    if (w[31:26] == 6'b011001 && w[15:14] == 2'b01) begin
      hit = 1;
      if (f == 0 || s + f > 32) ill = 1;
      else for (int i = 0; i < f; i++) res[i] = src[s + i];
    end else if (w[31:26] == 6'b011001 && w[15:14] == 2'b10) begin
      hit = 1;
      res = dst;
      if (f < s) ill = 1;
      else for (int i = 0; i <= f - s; i++) res[s + i] = src[i];
    end
  endtask

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: presents one word, pushes the expected item
  task automatic send(input logic [31:0] w, input logic [31:0] src,
                      input logic [31:0] dst, input string tag);
    bit hit; logic [31:0] r; logic ill;
    @(negedge clk); #1;
    instrWord = w; srcVal = src; dstVal = dst; inValid = 1'b1;
    model(w, src, dst, hit, r, ill);
    if (hit) sbQ.push_back('{res: r, idx: w[25:21], ill: ill, tag: tag});
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      inValid = 1'b0;
    end
  endtask

  // monitor: compares each strobe against the queue head
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbQ.size() == 0) begin
        check(0, "R2", "unexpected outValid", 32'd1, 32'd0);
      end else begin
        expItem_t e;
        e = sbQ.pop_front();
        check(outResult == e.res && outDstIdx == e.idx && outIllegal == e.ill,
              e.tag, "result/idx/illegal",
              {outIllegal, 2'b0, outDstIdx, outResult[23:0]},
              {e.ill, 2'b0, e.idx, e.res[23:0]});
        if (outResult != e.res) check(0, e.tag, "result word", outResult, e.res);
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(20000 * 10);
    check(0, "WATCHDOG", "timeout", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(outValid == 0 && outResult == 0 && outDstIdx == 0 && outIllegal == 0,
          "R9", "reset outputs", {outValid, outIllegal, outDstIdx, outResult[23:0]}, 32'd0);
    @(negedge clk); #1; rstN = 1'b1;

    // R4 extract cases, R1 decode
    send(mkWord(0, 3, 7, 8, 4),   32'hDEAD_BEEF, 32'h1111_1111, "R4");
    send(mkWord(0, 31, 1, 31, 0), 32'hFFFF_FFFF, 32'h0, "R4");
    send(mkWord(0, 1, 2, 1, 31),  32'h8000_0000, 32'h0, "R1");
    send(mkWord(0, 4, 2, 12, 20), 32'hA5C3_0F0F, 32'h0, "R4");
    // R5 / R6 illegal extract
    send(mkWord(0, 5, 2, 0, 3),   32'hFFFF_FFFF, 32'h0, "R5");
    send(mkWord(0, 6, 2, 13, 20), 32'hFFFF_FFFF, 32'h0, "R6");
    // R7 insert
    send(mkWord(1, 7, 3, 15, 8),  32'h0000_00AB, 32'h1234_5678, "R7");
    send(mkWord(1, 8, 3, 31, 31), 32'h0000_0001, 32'h0000_0000, "R7");
    send(mkWord(1, 9, 3, 4, 4),   32'h0000_0000, 32'hFFFF_FFFF, "R7");
    // R10 full-width insert
    send(mkWord(1, 10, 3, 31, 0), 32'hCAFE_F00D, 32'h0123_4567, "R10");
    // R8 reversed insert
    send(mkWord(1, 11, 3, 2, 9),  32'hFFFF_FFFF, 32'h5555_AAAA, "R8");
    idle(3);

    // R2: non-matching words
    send(32'h6400_C000 | mkWord(0, 2, 2, 5, 5), 32'h1, 32'h2, "R2");
    send(32'h6400_0000, 32'h1, 32'h2, "R2");
    send(32'h8400_4000, 32'h1, 32'h2, "R2");
    idle(2);
    check(sbQ.size() == 0 && outValid == 0, "R2", "no strobe on foreign opcode",
          {31'd0, outValid}, 32'd0);

    // R3: one pulse then low
    send(mkWord(0, 17, 1, 4, 0), 32'h0000_000F, 32'h0, "R3");
    idle(1);
    check(outValid == 1 && outDstIdx == 5'd17, "R3", "strobe one edge later",
          {26'd0, outValid, outDstIdx}, {26'd0, 1'b1, 5'd17});
    idle(1);
    check(outValid == 0, "R3", "strobe one cycle", {31'd0, outValid}, 32'd0);

    // mixed random stream, back-to-back
    for (int n = 0; n < 60; n++) begin
      logic [31:0] w;
      w = mkWord($urandom_range(0, 1), $urandom_range(0, 31), 0,
                 $urandom_range(0, 31), $urandom_range(0, 31));
      if ($urandom_range(0, 7) == 0) w[15:14] = 2'b11;
      send(w, $urandom, $urandom, w[14] ? "R4" : "R7");
    end
    idle(4);
    check(sbQ.size() == 0, "R3", "all results delivered", sbQ.size(), 32'd0);
    finish_run();
  end
endmodule